// File: doc/BRIEF.md
# Bank-Switched CPU Register File

This block holds the general-purpose registers of a small 8/16-bit microcontroller core. It has thirty-two bytes of storage, arranged as four banks of eight byte registers. Two bank-select bits in the program status word pick which bank is visible to the core. The core reads and writes the eight byte registers by name, or in pairs as 16-bit words. The same port also reaches the stack pointer, the status word and three 8-bit segment/control registers. Reads are combinational and writes take effect on the rising clock edge.

A second byte-wide port exposes all thirty-two bytes as a flat window, so the memory side of the core can reach any bank by offset. The active bank is placed in reverse: bank 0 occupies the top eight bytes of the window and bank 3 the bottom eight. If both ports write the same byte in one cycle, the named port wins and the flat port is told about the collision. A combinational condition evaluator turns the zero and carry flags, or a supplied value, into a branch-taken bit.

Top module: `rbank_regfile`

## Requirements
- R1: While `rst_n` is low at a rising edge, every window byte becomes 0x11, the status word becomes 0x06, the extra segment register becomes 0x0F, and the code segment register, the mode register and the stack pointer become 0x00/0x0000.
- R2: The active bank is status bit 5 × 2 + status bit 3. A byte register with index k (selector codes 1..8 for X, A, C, B, E, D, L, H give k = 0..7) lives at flat offset (3 − bank) × 8 + k.
- R3: Pair selectors 9..12 (AX, BC, DE, HL) read {odd byte, even byte} of register indices {1,0}, {3,2}, {5,4} and {7,6}. A pair write stores wr_data[15:8] in the odd byte and wr_data[7:0] in the even byte.
- R4: A status-word write that changes the bank bits redirects named accesses from the next cycle on. A byte write becomes visible on `rd_data` and `mm_rdata` right after its clock edge.
- R5: A stack-pointer write (selector 13) stores wr_data with bit 0 cleared. When wr_data[0] is 1, `sp_misaligned` is high for exactly the one cycle after that edge; otherwise it stays low.
- R6: Selector 0, or any code above 17, reads as 0x0000. A write with such a selector changes no register or window byte and pulses `wr_illegal` high for the one cycle after that edge.
- R7: `cond_true` is computed from cond_sel as follows: 0 gives val≠0, 1 gives val=0, 2 gives CY, 3 gives not CY, 4 gives neither Z nor CY, 5 gives Z or CY, 6 gives Z, and 7 gives not Z. Z is status bit 6 and CY is status bit 0.
- R8: The flat port reads `mm_rdata` = window byte `mm_addr` combinationally. With `mm_wr_en` high, it writes `mm_wdata` to that byte at the edge.
- R9: When the named port writes a byte that the flat port writes in the same cycle, the named data is stored and `mm_collide` is high during that cycle. Writes to distinct bytes both land and `mm_collide` stays low.
- R10: Selectors 14..17 (status word, code segment, extra segment, mode register) write wr_data[7:0] and read back zero-extended to 16 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_sel | input | 5 | Register selector for the named read |
| rd_data | output | 16 | Named read data, zero-extended for byte registers |
| wr_en | input | 1 | Named write enable |
| wr_sel | input | 5 | Register selector for the named write |
| wr_data | input | 16 | Named write data |
| wr_illegal | output | 1 | One-cycle pulse after a write to an invalid selector |
| sp_misaligned | output | 1 | One-cycle pulse after an odd stack-pointer write |
| mm_addr | input | 5 | Flat window byte offset |
| mm_wr_en | input | 1 | Flat write enable |
| mm_wdata | input | 8 | Flat write data |
| mm_rdata | output | 8 | Flat read data |
| mm_collide | output | 1 | Flat write loses to a named write this cycle |
| cond_sel | input | 3 | Branch condition code |
| cond_val | input | 8 | Value tested by the T/F conditions |
| cond_true | output | 1 | Condition result |

## Verification
The bench writes every byte of every bank by name and reads it back by flat offset. A decoder that put bank 0 at the bottom of the window, or that swapped the two bank bits, would land writes in the wrong eight bytes. It flips the bank bits and writes in the very next cycle, which exposes a bank select lagging one cycle. Pair writes are checked byte by byte, so a swapped high/low order shows up. Same-byte collisions are checked on both halves of a pair, where a reversed priority would keep the flat data. Writes to invalid selectors are followed by a full snapshot compare that would catch a stray write. Odd and even stack-pointer writes check both the cleared bit 0 and that the warning pulse is exactly one cycle wide.

// File: rtl/rbank_pkg.sv
// Package: rbank_pkg
// Shared selector codes, condition codes, status-word bit positions and the
// decoded access kind used across the banked register file.
// Assumes four banks of eight byte registers (two bank-select bits).
package rbank_pkg;

    localparam int NBANKS     = 4;
    localparam int BANK_BYTES = 8;
    localparam int WIN_BYTES  = NBANKS * BANK_BYTES;
    localparam int BANK_W     = $clog2(NBANKS);
    localparam int IDX_W      = $clog2(BANK_BYTES);
    localparam int WIN_AW     = BANK_W + IDX_W;
    localparam int SEL_W      = 5;
    localparam int CND_W      = 3;

    // Status word bit positions, MSB to LSB
    localparam int ST_IE   = 7;
    localparam int ST_Z    = 6;
    localparam int ST_BNK1 = 5;
    localparam int ST_AC   = 4;
    localparam int ST_BNK0 = 3;
    localparam int ST_PRI1 = 2;
    localparam int ST_PRI0 = 1;
    localparam int ST_CY   = 0;

    // Reset values
    localparam logic [7:0]  WIN_RST = 8'h11;
    localparam logic [7:0]  ST_RST  = 8'h06;
    localparam logic [7:0]  XSEG_RST = 8'h0F;
    localparam logic [7:0]  CSEG_RST = 8'h00;
    localparam logic [7:0]  MODE_RST = 8'h00;
    localparam logic [15:0] SP_RST   = 16'h0000;

    typedef enum logic [SEL_W-1:0] {
        RS_NONE = 5'd0,
        RS_X    = 5'd1,
        RS_A    = 5'd2,
        RS_C    = 5'd3,
        RS_B    = 5'd4,
        RS_E    = 5'd5,
        RS_D    = 5'd6,
        RS_L    = 5'd7,
        RS_H    = 5'd8,
        RS_AX   = 5'd9,
        RS_BC   = 5'd10,
        RS_DE   = 5'd11,
        RS_HL   = 5'd12,
        RS_SP   = 5'd13,
        RS_ST   = 5'd14,
        RS_CSEG = 5'd15,
        RS_XSEG = 5'd16,
        RS_MODE = 5'd17
    } rsel_e;

    typedef enum logic [CND_W-1:0] {
        CC_T  = 3'd0,
        CC_F  = 3'd1,
        CC_C  = 3'd2,
        CC_NC = 3'd3,
        CC_H  = 3'd4,
        CC_NH = 3'd5,
        CC_Z  = 3'd6,
        CC_NZ = 3'd7
    } cond_e;

    typedef enum logic [2:0] {
        AK_NONE,
        AK_BYTE,
        AK_PAIR,
        AK_SP,
        AK_ST,
        AK_CSEG,
        AK_XSEG,
        AK_MODE
    } akind_e;

    typedef struct packed {
        akind_e              kind;
        logic [WIN_AW-1:0]   addr;   // low byte offset in the window
    } access_t;

endpackage

// File: rtl/rbank_storage.sv
// Module: rbank_storage
// Flat byte array behind the register window. One named write port that
// updates up to two adjacent bytes, one flat byte write port, and
// combinational reads. The named port has priority on a same-byte clash.
// Assumes the high byte of a pair sits at the low byte offset plus one.
module rbank_storage
    import rbank_pkg::*;
#(
    parameter int         DEPTH   = WIN_BYTES,
    parameter logic [7:0] RST_VAL = WIN_RST,
    localparam int        AW      = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          nw_lo_en,
    input  logic          nw_hi_en,
    input  logic [AW-1:0] nw_addr,
    input  logic [7:0]    nw_lo_data,
    input  logic [7:0]    nw_hi_data,
    input  logic          fw_en,
    input  logic [AW-1:0] fw_addr,
    input  logic [7:0]    fw_data,
    input  logic [AW-1:0] nr_addr,
    output logic [7:0]    nr_lo_data,
    output logic [7:0]    nr_hi_data,
    output logic [7:0]    fr_data,
    output logic          fw_lost
);

    logic [7:0]    mem      [DEPTH];
    logic [7:0]    nxt_byte [DEPTH];
    logic          upd_byte [DEPTH];
    logic [AW-1:0] nw_hi_addr;
    logic [AW-1:0] nr_hi_addr;

    assign nw_hi_addr = nw_addr + AW'(1);
    assign nr_hi_addr = nr_addr + AW'(1);

    // Per-byte next value and update enable, named port first
    for (genvar gi = 0; gi < DEPTH; gi++) begin : g_byte
        logic hit_lo, hit_hi, hit_fw;
        assign hit_lo = nw_lo_en && (nw_addr    == AW'(gi));
        assign hit_hi = nw_hi_en && (nw_hi_addr == AW'(gi));
        assign hit_fw = fw_en    && (fw_addr    == AW'(gi));
        assign upd_byte[gi] = hit_lo || hit_hi || hit_fw;
        assign nxt_byte[gi] = hit_lo ? nw_lo_data :
                              hit_hi ? nw_hi_data : fw_data;
    end

    // Byte array update with synchronous reset
    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (!rst_n)
                mem[i] <= RST_VAL;
            else if (upd_byte[i])
                mem[i] <= nxt_byte[i];
        end
    end

    // Combinational read ports
    always_comb begin
        nr_lo_data = mem[nr_addr];
        nr_hi_data = mem[nr_hi_addr];
        fr_data    = mem[fw_addr];
    end

    // Flat write loses when it targets a byte the named port writes
    always_comb begin
        fw_lost = fw_en && ((nw_lo_en && (fw_addr == nw_addr)) ||
                            (nw_hi_en && (fw_addr == nw_hi_addr)));
    end

    assert_named_wins_lo_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (fw_en && nw_lo_en && (fw_addr == nw_addr))
        |=> (mem[$past(nw_addr)] == $past(nw_lo_data)));

    assert_named_wins_hi_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (fw_en && nw_hi_en && (fw_addr == nw_hi_addr))
        |=> (mem[$past(nw_hi_addr)] == $past(nw_hi_data)));

    assert_flat_write_lands_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (fw_en && !fw_lost) |=> (mem[$past(fw_addr)] == $past(fw_data)));

endmodule

// File: rtl/rbank_special.sv
// Module: rbank_special
// Stack pointer, status word and the three 8-bit segment/mode registers.
// Odd stack-pointer writes are stored even and raise a one-cycle warning.
// Assumes at most one write strobe is high per cycle (decoded upstream).
module rbank_special
    import rbank_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        sp_we,
    input  logic        st_we,
    input  logic        cseg_we,
    input  logic        xseg_we,
    input  logic        mode_we,
    input  logic [15:0] wdata,
    output logic [15:0] sp,
    output logic [7:0]  st,
    output logic [7:0]  cseg,
    output logic [7:0]  xseg,
    output logic [7:0]  mode,
    output logic        sp_odd
);

    // Stack pointer, low bit forced clear on write
    always_ff @(posedge clk) begin
        if (!rst_n)
            sp <= SP_RST;
        else if (sp_we)
            sp <= {wdata[15:1], 1'b0};
    end

    // One-cycle misalignment warning
    always_ff @(posedge clk) begin
        if (!rst_n)
            sp_odd <= 1'b0;
        else
            sp_odd <= sp_we && wdata[0];
    end

    // Status word
    always_ff @(posedge clk) begin
        if (!rst_n)
            st <= ST_RST;
        else if (st_we)
            st <= wdata[7:0];
    end

    // Segment and mode bytes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cseg <= CSEG_RST;
            xseg <= XSEG_RST;
            mode <= MODE_RST;
        end else begin
            if (cseg_we) cseg <= wdata[7:0];
            if (xseg_we) xseg <= wdata[7:0];
            if (mode_we) mode <= wdata[7:0];
        end
    end

    assert_sp_odd_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (sp_we && wdata[0]) |=> (sp_odd && (sp[0] == 1'b0)));

    assert_sp_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !sp_we |=> $stable(sp));

endmodule

// File: rtl/rbank_cond.sv
// Module: rbank_cond
// Combinational branch condition evaluator on the zero and carry flags,
// or on a supplied value for the true/false codes.
// Assumes the flags are taken from the current status word.
module rbank_cond
    import rbank_pkg::*;
(
    input  logic [CND_W-1:0] sel,
    input  logic [7:0]       val,
    input  logic             zf,
    input  logic             cf,
    output logic             taken
);

    // Condition decode
    always_comb begin
        unique case (sel)
            CC_T:    taken = (val != 8'h00);
            CC_F:    taken = (val == 8'h00);
            CC_C:    taken = cf;
            CC_NC:   taken = !cf;
            CC_H:    taken = !(zf || cf);
            CC_NH:   taken = zf || cf;
            CC_Z:    taken = zf;
            default: taken = !zf;
        endcase
    end

endmodule

// File: rtl/rbank_regfile.sv
// Module: rbank_regfile
// Banked register file top. Decodes named selectors against the active bank
// (reverse placement: bank n at window offset (3-n)*8), drives the byte
// array and special registers, and evaluates branch conditions.
// Assumes rd/wr selectors are sampled in the same cycle as wr_en.
module rbank_regfile
    import rbank_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SEL_W-1:0]  rd_sel,
    output logic [15:0]       rd_data,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [15:0]       wr_data,
    output logic              wr_illegal,
    output logic              sp_misaligned,
    input  logic [WIN_AW-1:0] mm_addr,
    input  logic              mm_wr_en,
    input  logic [7:0]        mm_wdata,
    output logic [7:0]        mm_rdata,
    output logic              mm_collide,
    input  logic [CND_W-1:0]  cond_sel,
    input  logic [7:0]        cond_val,
    output logic              cond_true
);

    logic [15:0]       sp_q;
    logic [7:0]        st_q, cseg_q, xseg_q, mode_q;
    logic [BANK_W-1:0] bank;
    logic [BANK_W-1:0] slot;
    logic [WIN_AW-1:0] bank_base;
    access_t           rd_acc, wr_acc;
    logic [7:0]        rd_lo, rd_hi;
    logic              nw_lo_en, nw_hi_en;

    // Map a selector onto an access kind and window byte offset
    function automatic access_t decode_sel(input logic [SEL_W-1:0] s,
                                           input logic [WIN_AW-1:0] base);
        access_t a;
        a.kind = AK_NONE;
        a.addr = base;
        if (s >= RS_X && s <= RS_H) begin
            a.kind = AK_BYTE;
            a.addr = base + WIN_AW'(s - RS_X);
        end else if (s >= RS_AX && s <= RS_HL) begin
            a.kind = AK_PAIR;
            a.addr = base + WIN_AW'({s - RS_AX, 1'b0});
        end else begin
            case (s)
                RS_SP:   a.kind = AK_SP;
                RS_ST:   a.kind = AK_ST;
                RS_CSEG: a.kind = AK_CSEG;
                RS_XSEG: a.kind = AK_XSEG;
                RS_MODE: a.kind = AK_MODE;
                default: a.kind = AK_NONE;
            endcase
        end
        return a;
    endfunction

    // Active bank and its reversed window base
    always_comb begin
        bank      = {st_q[ST_BNK1], st_q[ST_BNK0]};
        slot      = BANK_W'(NBANKS - 1) - bank;
        bank_base = {slot, {IDX_W{1'b0}}};
    end

    // Decode both named ports
    always_comb begin
        rd_acc = decode_sel(rd_sel, bank_base);
        wr_acc = decode_sel(wr_sel, bank_base);
    end

    // Window write strobes for the named port
    always_comb begin
        nw_lo_en = wr_en && ((wr_acc.kind == AK_BYTE) || (wr_acc.kind == AK_PAIR));
        nw_hi_en = wr_en && (wr_acc.kind == AK_PAIR);
    end

    rbank_storage #(
        .DEPTH   (WIN_BYTES),
        .RST_VAL (WIN_RST)
    ) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .nw_lo_en   (nw_lo_en),
        .nw_hi_en   (nw_hi_en),
        .nw_addr    (wr_acc.addr),
        .nw_lo_data (wr_data[7:0]),
        .nw_hi_data (wr_data[15:8]),
        .fw_en      (mm_wr_en),
        .fw_addr    (mm_addr),
        .fw_data    (mm_wdata),
        .nr_addr    (rd_acc.addr),
        .nr_lo_data (rd_lo),
        .nr_hi_data (rd_hi),
        .fr_data    (mm_rdata),
        .fw_lost    (mm_collide)
    );

    rbank_special u_spec (
        .clk     (clk),
        .rst_n   (rst_n),
        .sp_we   (wr_en && (wr_acc.kind == AK_SP)),
        .st_we   (wr_en && (wr_acc.kind == AK_ST)),
        .cseg_we (wr_en && (wr_acc.kind == AK_CSEG)),
        .xseg_we (wr_en && (wr_acc.kind == AK_XSEG)),
        .mode_we (wr_en && (wr_acc.kind == AK_MODE)),
        .wdata   (wr_data),
        .sp      (sp_q),
        .st      (st_q),
        .cseg    (cseg_q),
        .xseg    (xseg_q),
        .mode    (mode_q),
        .sp_odd  (sp_misaligned)
    );

    rbank_cond u_cond (
        .sel   (cond_sel),
        .val   (cond_val),
        .zf    (st_q[ST_Z]),
        .cf    (st_q[ST_CY]),
        .taken (cond_true)
    );

    // Named read multiplexer
    always_comb begin
        unique case (rd_acc.kind)
            AK_BYTE: rd_data = {8'h00, rd_lo};
            AK_PAIR: rd_data = {rd_hi, rd_lo};
            AK_SP:   rd_data = sp_q;
            AK_ST:   rd_data = {8'h00, st_q};
            AK_CSEG: rd_data = {8'h00, cseg_q};
            AK_XSEG: rd_data = {8'h00, xseg_q};
            AK_MODE: rd_data = {8'h00, mode_q};
            default: rd_data = 16'h0000;
        endcase
    end

    // One-cycle pulse for a write to an invalid selector
    always_ff @(posedge clk) begin
        if (!rst_n)
            wr_illegal <= 1'b0;
        else
            wr_illegal <= wr_en && (wr_acc.kind == AK_NONE);
    end

    assert_illegal_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_acc.kind == AK_NONE)) |=> wr_illegal);

    assert_illegal_no_change_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_acc.kind == AK_NONE))
        |=> ($stable(st_q) && $stable(sp_q) && $stable(cseg_q) &&
             $stable(xseg_q) && $stable(mode_q)));

    assert_bank_follows_status_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_acc.kind == AK_ST))
        |=> (bank == {$past(wr_data[ST_BNK1]), $past(wr_data[ST_BNK0])}));

    assert_collide_only_on_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mm_collide |-> (mm_wr_en && wr_en));

endmodule

// File: tb/rbank_regfile_bench.sv
module rbank_regfile_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  rd_sel = 5'd0;
    logic [15:0] rd_data;
    logic        wr_en = 1'b0;
    logic [4:0]  wr_sel = 5'd0;
    logic [15:0] wr_data = 16'h0;
    logic        wr_illegal, sp_misaligned;
    logic [4:0]  mm_addr = 5'd0;
    logic        mm_wr_en = 1'b0;
    logic [7:0]  mm_wdata = 8'h0;
    logic [7:0]  mm_rdata;
    logic        mm_collide;
    logic [2:0]  cond_sel = 3'd0;
    logic [7:0]  cond_val = 8'h0;
    logic        cond_true;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    rbank_regfile u_rbank_regfile (
        .clk(clk), .rst_n(rst_n),
        .rd_sel(rd_sel), .rd_data(rd_data),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .wr_illegal(wr_illegal), .sp_misaligned(sp_misaligned),
        .mm_addr(mm_addr), .mm_wr_en(mm_wr_en), .mm_wdata(mm_wdata),
        .mm_rdata(mm_rdata), .mm_collide(mm_collide),
        .cond_sel(cond_sel), .cond_val(cond_val), .cond_true(cond_true)
    );

    task automatic chk(input string tag, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic named_wr(input logic [4:0] s, input logic [15:0] d);
        @(negedge clk);
        wr_sel = s; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic flat_wr(input logic [4:0] a, input logic [7:0] d);
        @(negedge clk);
        mm_addr = a; mm_wdata = d; mm_wr_en = 1'b1;
        @(negedge clk);
        mm_wr_en = 1'b0;
    endtask

    task automatic rd(input logic [4:0] s, output logic [15:0] v);
        rd_sel = s; #0.5; v = rd_data;
    endtask

    task automatic mrd(input logic [4:0] a, output logic [7:0] v);
        mm_addr = a; #0.5; v = mm_rdata;
    endtask

    function automatic logic [7:0] st_bank(input int b);
        return 8'((((b >> 1) & 1) << 5) | ((b & 1) << 3));
    endfunction

    task automatic t_reset();
        logic [15:0] v; logic [7:0] m;
        @(negedge clk);
        for (int i = 0; i < 32; i++) begin
            mrd(5'(i), m);
            chk("R1", $sformatf("window byte %0d", i), {8'h0, m}, 16'h0011);
        end
        rd(5'd14, v); chk("R1", "status", v, 16'h0006);
        rd(5'd16, v); chk("R1", "extra seg", v, 16'h000F);
        rd(5'd15, v); chk("R1", "code seg", v, 16'h0000);
        rd(5'd17, v); chk("R1", "mode", v, 16'h0000);
        rd(5'd13, v); chk("R1", "stack ptr", v, 16'h0000);
        chk("R1", "flags idle", {14'h0, wr_illegal, sp_misaligned}, 16'h0);
    endtask

    task automatic t_banks();
        logic [7:0] m; logic [15:0] v;
        for (int b = 0; b < 4; b++) begin
            named_wr(5'd14, {8'h0, st_bank(b)});
            for (int k = 0; k < 8; k++)
                named_wr(5'(k + 1), {8'h0, 8'(8'h20 + b * 16 + k)});
        end
        for (int b = 0; b < 4; b++)
            for (int k = 0; k < 8; k++) begin
                mrd(5'((3 - b) * 8 + k), m);
                chk("R2", $sformatf("bank %0d reg %0d", b, k), {8'h0, m},
                    {8'h0, 8'(8'h20 + b * 16 + k)});
            end
        named_wr(5'd14, {8'h0, st_bank(2)});
        rd(5'd8, v);
        chk("R2", "H read in bank 2", v, 16'h0047);
    endtask

    task automatic t_bank_switch();
        logic [7:0] m; logic [15:0] v;
        named_wr(5'd14, {8'h0, st_bank(0)});
        @(negedge clk);
        wr_sel = 5'd14; wr_data = {8'h0, st_bank(1)}; wr_en = 1'b1;
        @(negedge clk);
        wr_sel = 5'd2; wr_data = 16'h00C3;
        @(negedge clk);
        wr_en = 1'b0;
        mrd(5'd17, m); chk("R4", "A lands in bank 1", {8'h0, m}, 16'h00C3);
        mrd(5'd25, m); chk("R4", "bank 0 A untouched", {8'h0, m}, 16'h0021);
        rd(5'd2, v); chk("R4", "A read right after edge", v, 16'h00C3);
    endtask

    task automatic t_pairs();
        logic [7:0] m; logic [15:0] v;
        named_wr(5'd14, {8'h0, st_bank(0)});
        named_wr(5'd9, 16'h1234);
        rd(5'd2, v);  chk("R3", "A from AX", v, 16'h0012);
        rd(5'd1, v);  chk("R3", "X from AX", v, 16'h0034);
        mrd(5'd24, m); chk("R3", "flat X", {8'h0, m}, 16'h0034);
        mrd(5'd25, m); chk("R3", "flat A", {8'h0, m}, 16'h0012);
        named_wr(5'd4, 16'h00AB);
        named_wr(5'd3, 16'h00CD);
        rd(5'd10, v); chk("R3", "BC from bytes", v, 16'hABCD);
        named_wr(5'd11, 16'h5E6F);
        rd(5'd6, v);  chk("R3", "D from DE", v, 16'h005E);
        rd(5'd5, v);  chk("R3", "E from DE", v, 16'h006F);
        named_wr(5'd12, 16'h8899);
        rd(5'd12, v); chk("R3", "HL readback", v, 16'h8899);
        mrd(5'd31, m); chk("R3", "flat H", {8'h0, m}, 16'h0088);
    endtask

    task automatic t_sp();
        logic [15:0] v;
        named_wr(5'd13, 16'h1235);
        chk("R5", "warn after odd write", {15'h0, sp_misaligned}, 16'h1);
        rd(5'd13, v); chk("R5", "odd value stored even", v, 16'h1234);
        @(negedge clk);
        chk("R5", "warn one cycle only", {15'h0, sp_misaligned}, 16'h0);
        named_wr(5'd13, 16'hFFFE);
        chk("R5", "no warn on even write", {15'h0, sp_misaligned}, 16'h0);
        rd(5'd13, v); chk("R5", "even value stored", v, 16'hFFFE);
    endtask

    task automatic t_illegal();
        logic [7:0] snap [32];
        logic [15:0] sv [5];
        logic [7:0] m; logic [15:0] v;
        logic [4:0] bad [2];
        bad[0] = 5'd0; bad[1] = 5'd31;
        rd(5'd0, v);  chk("R6", "none reads zero", v, 16'h0000);
        rd(5'd20, v); chk("R6", "unused code reads zero", v, 16'h0000);
        for (int j = 0; j < 2; j++) begin
            for (int i = 0; i < 32; i++) mrd(5'(i), snap[i]);
            for (int i = 0; i < 5; i++) rd(5'(13 + i), sv[i]);
            named_wr(bad[j], 16'hFFFF);
            chk("R6", $sformatf("illegal pulse sel %0d", bad[j]), {15'h0, wr_illegal}, 16'h1);
            for (int i = 0; i < 32; i++) begin
                mrd(5'(i), m);
                chk("R6", $sformatf("byte %0d unchanged", i), {8'h0, m}, {8'h0, snap[i]});
            end
            for (int i = 0; i < 5; i++) begin
                rd(5'(13 + i), v);
                chk("R6", $sformatf("special %0d unchanged", 13 + i), v, sv[i]);
            end
            @(negedge clk);
            chk("R6", "illegal pulse ends", {15'h0, wr_illegal}, 16'h0);
        end
    endtask

    task automatic t_cond();
        bit z, c, e;
        for (int zc = 0; zc < 4; zc++) begin
            z = zc[1]; c = zc[0];
            named_wr(5'd14, {8'h0, 1'b0, z, 5'b0, c});
            for (int s = 0; s < 8; s++) begin
                for (int vv = 0; vv < 2; vv++) begin
                    cond_sel = 3'(s); cond_val = vv ? 8'h05 : 8'h00;
                    #0.5;
                    case (s)
                        0: e = (vv != 0);
                        1: e = (vv == 0);
                        2: e = c;
                        3: e = !c;
                        4: e = !(z || c);
                        5: e = z || c;
                        6: e = z;
                        default: e = !z;
                    endcase
                    chk("R7", $sformatf("cond %0d z%0d c%0d v%0d", s, z, c, vv),
                        {15'h0, cond_true}, {15'h0, e});
                end
            end
        end
        named_wr(5'd14, 16'h0000);
    endtask

    task automatic t_flat();
        logic [7:0] m; logic [15:0] v;
        flat_wr(5'd5, 8'h5A);
        mrd(5'd5, m); chk("R8", "flat readback", {8'h0, m}, 16'h005A);
        named_wr(5'd14, {8'h0, st_bank(3)});
        rd(5'd6, v); chk("R8", "flat byte seen as bank 3 D", v, 16'h005A);
        flat_wr(5'd30, 8'hE7);
        named_wr(5'd14, {8'h0, st_bank(0)});
        rd(5'd7, v); chk("R8", "flat byte seen as bank 0 L", v, 16'h00E7);
    endtask

    task automatic t_collide();
        logic [7:0] m;
        named_wr(5'd14, {8'h0, st_bank(0)});
        @(negedge clk);
        wr_sel = 5'd1; wr_data = 16'h0077; wr_en = 1'b1;
        mm_addr = 5'd24; mm_wdata = 8'h99; mm_wr_en = 1'b1;
        #0.5; chk("R9", "collide flag same byte", {15'h0, mm_collide}, 16'h1);
        @(negedge clk);
        wr_en = 1'b0; mm_wr_en = 1'b0;
        mrd(5'd24, m); chk("R9", "named wins byte", {8'h0, m}, 16'h0077);
        @(negedge clk);
        wr_sel = 5'd9; wr_data = 16'hA1B2; wr_en = 1'b1;
        mm_addr = 5'd25; mm_wdata = 8'h3C; mm_wr_en = 1'b1;
        #0.5; chk("R9", "collide flag pair high", {15'h0, mm_collide}, 16'h1);
        @(negedge clk);
        wr_en = 1'b0; mm_wr_en = 1'b0;
        mrd(5'd25, m); chk("R9", "named wins pair high", {8'h0, m}, 16'h00A1);
        @(negedge clk);
        wr_sel = 5'd3; wr_data = 16'h0011; wr_en = 1'b1;
        mm_addr = 5'd3; mm_wdata = 8'h42; mm_wr_en = 1'b1;
        #0.5; chk("R9", "no collide distinct", {15'h0, mm_collide}, 16'h0);
        @(negedge clk);
        wr_en = 1'b0; mm_wr_en = 1'b0;
        mrd(5'd26, m); chk("R9", "named lands distinct", {8'h0, m}, 16'h0011);
        mrd(5'd3, m);  chk("R9", "flat lands distinct", {8'h0, m}, 16'h0042);
    endtask

    task automatic t_special();
        logic [15:0] v;
        named_wr(5'd15, 16'hFF0A);
        named_wr(5'd16, 16'hEE03);
        named_wr(5'd17, 16'hDD01);
        named_wr(5'd14, 16'hCC46);
        rd(5'd15, v); chk("R10", "code seg", v, 16'h000A);
        rd(5'd16, v); chk("R10", "extra seg", v, 16'h0003);
        rd(5'd17, v); chk("R10", "mode", v, 16'h0001);
        rd(5'd14, v); chk("R10", "status", v, 16'h0046);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_banks();
        t_bank_switch();
        t_pairs();
        t_sp();
        t_illegal();
        t_cond();
        t_flat();
        t_collide();
        t_special();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

endmodule